// File: doc/BRIEF.md
# Processor Startup Wake Sequencer

This block wakes a sleeping processor, or every processor except the requester, with the usual three-message handshake. A one-cycle start command carries a target identifier, a broadcast flag and the physical address of the startup routine. The sequencer checks the address first. It then drives the interrupt command unit's request port through three messages: a reset-class message, a first startup message, and an identical second startup message. Fixed waits are timed between the messages.

Every message is held on the request port until the command unit accepts it. Each wait is counted from that acceptance. The length of a microsecond is set by the parameter `CYCLES_PER_US`, so the two waits are 10 µs and 200 µs at any clock rate. The block gives a one-cycle completion pulse at the end of a good sequence. It gives a one-cycle error pulse when a start is refused. How the woken processor behaves is outside this block.

Top module: `sipi_seq`

## Requirements
- R1: While reset is held and right after it, `req_valid_o`, `busy_o`, `done_o` and `error_o` are all 0.
- R2: A start whose address is 0x100000 or above, or whose bits [11:0] are not all zero, is refused. `error_o` goes to 1 for exactly the one cycle after the command. No request is issued and `busy_o` stays 0.
- R3: A good start produces exactly three requests, in this order. The first has mode 3'b101 (reset-class message) and vector 0. The second and third both have mode 3'b110 (startup message). Every request has `req_level_o` = 1.
- R4: Both startup requests carry vector = address bits [19:12] (the address shifted right by 12).
- R5: After the first request is accepted, `req_valid_o` stays 0 for exactly 10*CYCLES_PER_US cycles before the first startup request appears.
- R6: After the first startup request is accepted, `req_valid_o` stays 0 for exactly 200*CYCLES_PER_US cycles before the second startup request appears.
- R7: A request stays valid, with unchanged fields, in every cycle until `req_accept_i` is sampled high. The sequence does not move on before that acceptance.
- R8: With the broadcast flag at 0, every request has destination = target and shorthand 2'b00. With the flag at 1, every request has destination 0 and shorthand 2'b11 (all excluding self).
- R9: A start command that arrives while `busy_o` is 1 is ignored. Targets, vectors and timing of the sequence in progress do not change.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the second startup request is accepted.
- R11: `busy_o` is 1 from the cycle after a good start until the second startup request is accepted. It is 0 in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start command |
| start_target_i | input | ID_W | Target processor identifier |
| start_bcast_i | input | 1 | 1 = all processors except self |
| start_addr_i | input | ADDR_W | Startup routine physical address |
| req_valid_o | output | 1 | Request to the command unit |
| req_accept_i | input | 1 | Command unit accepted the request |
| req_mode_o | output | 3 | Message mode (3'b101 reset-class, 3'b110 startup) |
| req_vector_o | output | 8 | Message vector |
| req_level_o | output | 1 | Level bit, always 1 |
| req_shorthand_o | output | 2 | Destination shorthand (2'b00 none, 2'b11 all excluding self) |
| req_dest_o | output | ID_W | Destination identifier |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle refused-start pulse |

## Verification
Some rules can be checked on every clock, and the assertions do that. They check the hold-until-accept rule, the single-cycle width of the done and error pulses, and that an error leaves the port idle. They also check that broadcast requests carry destination 0, that the reset-class message has vector 0, and that the captured command stays frozen while busy. The delay counter is checked for exact one-step decrements and exact loads. Other properties can only be shown by the bench scenarios, because they depend on a whole sequence. These are the exact gap lengths measured from acceptance, the ordering of the three messages, vector extraction at the address boundaries, rejection of out-of-range and misaligned addresses, and a start command injected mid-sequence having no effect.

// File: rtl/sipi_pkg.sv
package sipi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_GAP1,
    ST_SIPI1,
    ST_GAP2,
    ST_SIPI2
  } seq_state_e;

  localparam logic [2:0] DM_INIT    = 3'b101;
  localparam logic [2:0] DM_STARTUP = 3'b110;

  localparam logic [1:0] SH_NONE     = 2'b00;
  localparam logic [1:0] SH_ALL_EXCL = 2'b11;

endpackage

// File: rtl/sipi_addr_check.sv
module sipi_addr_check #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int LIMIT_BITS = 20,
  localparam int VEC_W     = LIMIT_BITS - PAGE_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic [VEC_W-1:0]  vec_o
);

  logic in_range;
  logic aligned;

  generate
    if (ADDR_W > LIMIT_BITS) begin : g_hi
      assign in_range = ~|addr_i[ADDR_W-1:LIMIT_BITS];
    end else begin : g_nohi
      assign in_range = 1'b1;
    end
  endgenerate

  assign aligned = ~|addr_i[PAGE_BITS-1:0];
  assign ok_o    = in_range & aligned;
  assign vec_o   = addr_i[LIMIT_BITS-1:PAGE_BITS];

endmodule

// File: rtl/sipi_gap_timer.sv
module sipi_gap_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R6

endmodule

// File: rtl/sipi_seq_fsm.sv
module sipi_seq_fsm
  import sipi_pkg::*;
#(
  parameter int ID_W  = 32,
  parameter int VEC_W = 8,
  parameter int CNT_W = 10,
  parameter logic [CNT_W-1:0] SHORT_LOAD = '0,
  parameter logic [CNT_W-1:0] LONG_LOAD  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ID_W-1:0]  target_i,
  input  logic             bcast_i,
  input  logic             accept_i,
  input  logic             timer_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             req_valid_o,
  output logic [2:0]       req_mode_o,
  output logic [VEC_W-1:0] req_vector_o,
  output logic             req_level_o,
  output logic [1:0]       req_shorthand_o,
  output logic [ID_W-1:0]  req_dest_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);

  seq_state_e       state_q, state_d;
  logic [ID_W-1:0]  tgt_q;
  logic             bcast_q;
  logic [VEC_W-1:0] vec_q;
  logic             cap_en;
  logic             done_q, done_d;
  logic             err_q, err_d;

  always_comb begin
    state_d    = state_q;
    cap_en     = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (ok_i) begin
            state_d = ST_INIT;
            cap_en  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_INIT: begin
        if (accept_i) begin
          state_d    = ST_GAP1;
          load_o     = 1'b1;
          load_val_o = SHORT_LOAD;
        end
      end
      ST_GAP1: begin
        if (timer_zero_i) state_d = ST_SIPI1;
      end
      ST_SIPI1: begin
        if (accept_i) begin
          state_d    = ST_GAP2;
          load_o     = 1'b1;
          load_val_o = LONG_LOAD;
        end
      end
      ST_GAP2: begin
        if (timer_zero_i) state_d = ST_SIPI2;
      end
      ST_SIPI2: begin
        if (accept_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      bcast_q <= 1'b0;
      vec_q   <= '0;
    end else if (cap_en) begin
      tgt_q   <= target_i;
      bcast_q <= bcast_i;
      vec_q   <= vec_i;
    end
  end

  always_comb begin
    req_valid_o     = (state_q == ST_INIT) || (state_q == ST_SIPI1) ||
                      (state_q == ST_SIPI2);
    req_mode_o      = (state_q == ST_INIT) ? DM_INIT : DM_STARTUP;
    req_vector_o    = (state_q == ST_INIT) ? '0 : vec_q;
    req_level_o     = 1'b1;
    req_shorthand_o = bcast_q ? SH_ALL_EXCL : SH_NONE;
    req_dest_o      = bcast_q ? '0 : tgt_q;
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !accept_i) |=> (req_valid_o && $stable(req_mode_o) &&
      $stable(req_vector_o) && $stable(req_dest_o))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o); // R2
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!busy_o && !req_valid_o)); // R2
  AST_BCAST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_shorthand_o == SH_ALL_EXCL) |-> (req_dest_o == '0)); // R8
  AST_INIT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_mode_o == DM_INIT) |-> (req_vector_o == '0)); // R3
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(tgt_q) && $stable(vec_q) && $stable(bcast_q))); // R9

endmodule

// File: rtl/sipi_seq.sv
module sipi_seq
  import sipi_pkg::*;
#(
  parameter int ID_W          = 32,
  parameter int ADDR_W        = 32,
  parameter int CYCLES_PER_US = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   start_target_i,
  input  logic              start_bcast_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              req_valid_o,
  input  logic              req_accept_i,
  output logic [2:0]        req_mode_o,
  output logic [7:0]        req_vector_o,
  output logic              req_level_o,
  output logic [1:0]        req_shorthand_o,
  output logic [ID_W-1:0]   req_dest_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int PAGE_BITS  = 12;
  localparam int LIMIT_BITS = 20;
  localparam int VEC_W      = LIMIT_BITS - PAGE_BITS;
  localparam int SHORT_CYC  = 10 * CYCLES_PER_US;
  localparam int LONG_CYC   = 200 * CYCLES_PER_US;
  localparam int CNT_W      = $clog2(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);

  logic             addr_ok;
  logic [VEC_W-1:0] addr_vec;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_load_val;
  logic             tmr_zero;

  sipi_addr_check #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .LIMIT_BITS (LIMIT_BITS)
  ) u_addr_check (
    .addr_i (start_addr_i),
    .ok_o   (addr_ok),
    .vec_o  (addr_vec)
  );

  sipi_gap_timer #(
    .CNT_W (CNT_W)
  ) u_gap_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_load_val),
    .zero_o     (tmr_zero)
  );

  sipi_seq_fsm #(
    .ID_W       (ID_W),
    .VEC_W      (VEC_W),
    .CNT_W      (CNT_W),
    .SHORT_LOAD (SHORT_LOAD),
    .LONG_LOAD  (LONG_LOAD)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .ok_i            (addr_ok),
    .vec_i           (addr_vec),
    .target_i        (start_target_i),
    .bcast_i         (start_bcast_i),
    .accept_i        (req_accept_i),
    .timer_zero_i    (tmr_zero),
    .load_o          (tmr_load),
    .load_val_o      (tmr_load_val),
    .req_valid_o     (req_valid_o),
    .req_mode_o      (req_mode_o),
    .req_vector_o    (req_vector_o),
    .req_level_o     (req_level_o),
    .req_shorthand_o (req_shorthand_o),
    .req_dest_o      (req_dest_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .error_o         (error_o)
  );

endmodule

// File: tb/sipi_seq_tb.sv
module sipi_seq_tb;

  localparam int CPU   = 2;
  localparam int SHORT = 10 * CPU;
  localparam int LONG  = 200 * CPU;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_target_i;
  logic        start_bcast_i;
  logic [31:0] start_addr_i;
  logic        req_valid_o;
  logic        req_accept_i;
  logic [2:0]  req_mode_o;
  logic [7:0]  req_vector_o;
  logic        req_level_o;
  logic [1:0]  req_shorthand_o;
  logic [31:0] req_dest_o;
  logic        busy_o;
  logic        done_o;
  logic        error_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sipi_seq #(.ID_W(32), .ADDR_W(32), .CYCLES_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .start_target_i(start_target_i), .start_bcast_i(start_bcast_i),
    .start_addr_i(start_addr_i), .req_valid_o(req_valid_o),
    .req_accept_i(req_accept_i), .req_mode_o(req_mode_o),
    .req_vector_o(req_vector_o), .req_level_o(req_level_o),
    .req_shorthand_o(req_shorthand_o), .req_dest_o(req_dest_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; start_target_i = '0; start_bcast_i = 1'b0;
    start_addr_i = '0; req_accept_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, req_valid_o}, 0);
    chk("R1 busy in reset", {31'b0, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {31'b0, done_o}, 0);
    chk("R1 error after reset", {31'b0, error_o}, 0);
    chk("R1 valid after reset", {31'b0, req_valid_o}, 0);
  endtask

  task automatic t_bad_addr(input logic [31:0] addr);
    start_i = 1'b1; start_addr_i = addr; start_target_i = 32'h3;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 error pulse", {31'b0, error_o}, 1);
    chk("R2 busy stays low", {31'b0, busy_o}, 0);
    chk("R2 no request", {31'b0, req_valid_o}, 0);
    @(negedge clk);
    chk("R2 error one cycle", {31'b0, error_o}, 0);
    chk("R2 still no request", {31'b0, req_valid_o}, 0);
  endtask

  task automatic t_seq(input logic [31:0] tgt, input bit bc, input logic [31:0] addr,
                       input int lat, input bit poke);
    logic [31:0] exp_dest;
    logic [1:0]  exp_sh;
    exp_dest = bc ? 32'h0 : tgt;
    exp_sh   = bc ? 2'b11 : 2'b00;
    start_i = 1'b1; start_target_i = tgt; start_bcast_i = bc; start_addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 busy after start", {31'b0, busy_o}, 1);
    for (int i = 0; i < 3; i++) begin
      int gap;
      int exp_gap;
      gap = 0;
      exp_gap = (i == 0) ? 0 : ((i == 1) ? SHORT : LONG);
      while (!req_valid_o && gap <= LONG + 10) begin
        @(negedge clk);
        gap++;
      end
      if (i == 1) chk("R5 short gap", gap, exp_gap);
      else if (i == 2) chk("R6 long gap", gap, exp_gap);
      else chk("R3 first request immediate", gap, exp_gap);
      chk("R3 mode order", {29'b0, req_mode_o}, (i == 0) ? 32'h5 : 32'h6);
      chk("R3 level bit", {31'b0, req_level_o}, 1);
      chk("R4 vector", {24'b0, req_vector_o}, (i == 0) ? 32'h0 : {24'b0, addr[19:12]});
      chk("R8 destination", req_dest_o, exp_dest);
      chk("R8 shorthand", {30'b0, req_shorthand_o}, {30'b0, exp_sh});
      for (int k = 0; k < lat; k++) begin
        if (poke && i == 1 && k == 0) begin
          start_i = 1'b1; start_target_i = tgt ^ 32'h55; start_bcast_i = ~bc;
          start_addr_i = 32'h01000;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 held until accept", {31'b0, req_valid_o}, 1);
        chk("R7 mode stable", {29'b0, req_mode_o}, (i == 0) ? 32'h5 : 32'h6);
        chk("R9 dest unchanged while busy", req_dest_o, exp_dest);
      end
      req_accept_i = 1'b1;
      @(negedge clk);
      req_accept_i = 1'b0;
      if (i == 2) begin
        chk("R10 done pulse", {31'b0, done_o}, 1);
        chk("R11 busy low at done", {31'b0, busy_o}, 0);
        @(negedge clk);
        chk("R10 done one cycle", {31'b0, done_o}, 0);
        chk("R3 no fourth request", {31'b0, req_valid_o}, 0);
      end else begin
        chk("R10 no early done", {31'b0, done_o}, 0);
        chk("R11 busy during gap", {31'b0, busy_o}, 1);
        chk("R7 request dropped after accept", {31'b0, req_valid_o}, 0);
      end
    end
  endtask

  initial begin
    t_reset();
    t_seq(32'h0000_0005, 1'b0, 32'h0009_A000, 0, 1'b0);
    t_seq(32'h0000_00AB, 1'b1, 32'h000F_F000, 3, 1'b1);
    t_bad_addr(32'h0010_0000);
    t_bad_addr(32'h0000_1800);
    t_seq(32'h0000_0007, 1'b0, 32'h0000_0000, 1, 1'b1);
    t_bad_addr(32'hFFFF_F000);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=sequence complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule